// File: doc/BRIEF.md
# SPI Master Transaction Engine

This block is a register-mapped SPI master that runs a whole chip-select-framed transaction from one host command. The host fills a transmit FIFO through a data register, programs a transfer-control register with a phase code and two byte counts, then writes the command register. The engine drops chip select, shifts out the write-phase bytes, optionally follows them with a read phase that fills a receive FIFO, and raises chip select again. The host drains received bytes by reading the same data register.

The serial clock is derived from the system clock by a programmable divider. The frame length per byte is programmable. Three self-clearing soft-reset bits let the host flush either FIFO or abort the controller. A status register reports busy, transmit-FIFO empty and full, and the receive-FIFO fill level. Only SPI mode 0 with MSB-first framing is offered. When the transmit FIFO runs dry during a write phase, or the receive FIFO is full during a read phase, the engine pauses the serial clock at a byte boundary instead of losing data.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, status (offset 0x34) reads busy (bit 0) low, TX-empty (bit 22) high, TX-full (bit 23) low and RX level (bits 12:8) zero; chip select is high and SCLK low; the format register (0x10) reads 7 in bits 12:8; the timing register (0x40) reads the DIV_RST parameter.
- R2: Phase code 1 in transfer-control (0x20) bits 27:24 sends write-count+1 bytes from the TX FIFO, where bits 20:12 hold the count minus one, MSB first with data changing on falling SCLK and stable at rising SCLK; the RX FIFO is left untouched.
- R3: Phase code 2 clocks read-count+1 bytes (bits 8:0, count minus one) from MISO into the RX FIFO while MOSI stays low; the RX level in status bits 12:8 follows, and each read of the data register (0x2C) pops one byte.
- R4: Phase code 3 sends all write-phase bytes and then reads the read-phase bytes inside one continuous chip-select-low window; only read-phase bytes enter the RX FIFO.
- R5: A write of any value to the command register (0x24) launches a transaction with the current transfer-control settings, and busy is high from the next cycle until chip select has returned high.
- R6: A command write while the phase code is not 1, 2 or 3 starts nothing: busy stays low and the TX FIFO keeps its contents.
- R7: Writing bit 0, 1 or 2 of the control register (0x30) resets the controller, the RX FIFO or the TX FIFO respectively; the bits read back zero once the reset has been applied, and a controller reset aborts a running transaction with chip select returning high.
- R8: Writes to the data register push the TX FIFO; status bit 23 is set when it holds FIFO_DEPTH entries, and a push while full is discarded.
- R9: A data-register read while the RX FIFO is empty returns zero.
- R10: An empty TX FIFO during the write phase, or a full RX FIFO during the read phase, holds SCLK low with chip select low until data or space arrives, with no byte lost or duplicated.
- R11: Chip select falls at least half an SCLK period before the first rising SCLK edge, and SCLK is high only while chip select is low.
- R12: The SCLK period is 2*(div+1) system clocks, where div is timing register bits 7:0, and SCLK changes only at the end of a divider half-period.
- R13: Format bits 12:8 hold the frame length minus one; values above 7 give an 8-bit frame; a shorter frame produces that many SCLK pulses per byte carrying the low bits of the byte, MSB of the frame first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops RX FIFO on data register) |
| regAddr | input | 7 | Byte address of the register |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the strobe cycle |
| sclkO | output | 1 | Serial clock, idles low |
| csNO | output | 1 | Active-low chip select |
| mosiO | output | 1 | Serial data to the device |
| misoI | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with FIFO_DEPTH set to 4 and DIV_RST set to 1. The shallow FIFOs put the full flag, the dropped push and both stall conditions within a handful of bytes, so a six-byte transfer is enough to stall the write phase on an empty TX FIFO and the read phase on a full RX FIFO. The small divider keeps each byte short while still letting one test raise the divider to 2 and measure the resulting SCLK period and chip-select lead time in system clocks.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 9;
  localparam int DIV_W  = 8;
  localparam int MODE_W = 4;
  localparam int BIT_W  = $clog2(DATA_W);

  localparam logic [MODE_W-1:0] MODE_WO = 4'd1;
  localparam logic [MODE_W-1:0] MODE_RO = 4'd2;
  localparam logic [MODE_W-1:0] MODE_WR = 4'd3;

  localparam logic [6:0] A_FMT  = 7'h10;
  localparam logic [6:0] A_TCTL = 7'h20;
  localparam logic [6:0] A_CMD  = 7'h24;
  localparam logic [6:0] A_DATA = 7'h2C;
  localparam logic [6:0] A_CTL  = 7'h30;
  localparam logic [6:0] A_STAT = 7'h34;
  localparam logic [6:0] A_TIM  = 7'h40;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [CNT_W-1:0]  wcnt;
    logic [CNT_W-1:0]  rcnt;
    logic [DIV_W-1:0]  div;
    logic [BIT_W-1:0]  bitsM1;
  } cfg_t;

  typedef struct packed {
    logic ldByte;
    logic ldTx;
    logic sample;
    logic shift;
    logic rxPush;
  } strb_t;
endpackage

// File: rtl/spi_xfer_fifo.sv
`timescale 1ns/1ps
module spi_xfer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R8
  push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/spi_xfer_dp.sv
`timescale 1ns/1ps
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter logic [7:0]  DIV_RST    = 8'd3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        misoI,
  output logic        mosiO,
  input  strb_t       strb,
  input  logic        busy,
  output cfg_t        cfg,
  output logic        start,
  output logic        ctlRst,
  output logic        txEmpty,
  output logic        rxFull
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [4:0]        fmtLen;
  logic [MODE_W-1:0] mode;
  logic [CNT_W-1:0]  wcnt, rcnt;
  logic [DIV_W-1:0]  div;
  logic [2:0]        rstPend;
  logic [BIT_W-1:0]  bitsM1;
  logic              wrFmt, wrTctl, wrCtl, wrTim, txPush, rxPop;
  logic [DATA_W-1:0] txHead, rxHead, txSh, rxSh;
  logic [CW-1:0]     txCnt, rxCnt;
  logic              txFull, rxEmpty;
  logic [31:0]       stat;
  logic              unusedBits;

  assign wrFmt  = regWr && (regAddr == A_FMT);
  assign wrTctl = regWr && (regAddr == A_TCTL);
  assign wrCtl  = regWr && (regAddr == A_CTL);
  assign wrTim  = regWr && (regAddr == A_TIM);
  assign start  = regWr && (regAddr == A_CMD);
  assign txPush = regWr && (regAddr == A_DATA);
  assign rxPop  = regRd && (regAddr == A_DATA);
  assign ctlRst = rstPend[0];
  assign unusedBits = ^{regWdata, txCnt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtLen  <= 5'd7;
      mode    <= '0;
      wcnt    <= '0;
      rcnt    <= '0;
      div     <= DIV_RST;
      rstPend <= '0;
    end else begin
      rstPend <= wrCtl ? regWdata[2:0] : 3'b000;
      if (wrFmt) fmtLen <= regWdata[12:8];
      if (wrTctl) begin
        mode <= regWdata[27:24];
        wcnt <= regWdata[20:12];
        rcnt <= regWdata[8:0];
      end
      if (wrTim) div <= regWdata[7:0];
    end
  end

  assign bitsM1 = (fmtLen > 5'(DATA_W-1)) ? BIT_W'(DATA_W-1) : fmtLen[BIT_W-1:0];

  always_comb begin
    cfg.mode   = mode;
    cfg.wcnt   = wcnt;
    cfg.rcnt   = rcnt;
    cfg.div    = div;
    cfg.bitsM1 = bitsM1;
  end

  spi_xfer_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .clr(rstPend[2]), .push(txPush), .din(regWdata[DATA_W-1:0]),
    .pop(strb.ldByte && strb.ldTx), .dout(txHead), .count(txCnt), .full(txFull), .empty(txEmpty));

  spi_xfer_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .clr(rstPend[1]), .push(strb.rxPush), .din(rxSh),
    .pop(rxPop), .dout(rxHead), .count(rxCnt), .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (strb.ldByte)
        txSh <= strb.ldTx ? (txHead << (BIT_W'(DATA_W-1) - bitsM1)) : '0;
      else if (strb.shift)
        txSh <= txSh << 1;
      if (strb.ldByte)
        rxSh <= '0;
      else if (strb.sample)
        rxSh <= {rxSh[DATA_W-2:0], misoI};
    end
  end

  assign mosiO = txSh[DATA_W-1];

  always_comb begin
    stat       = '0;
    stat[0]    = busy;
    stat[12:8] = 5'(rxCnt);
    stat[22]   = txEmpty;
    stat[23]   = txFull;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_FMT:  regRdata[12:8] = fmtLen;
      A_TCTL: regRdata = {4'b0, mode, 3'b0, wcnt, 3'b0, rcnt};
      A_DATA: regRdata[DATA_W-1:0] = rxEmpty ? '0 : rxHead;
      A_CTL:  regRdata[2:0] = rstPend;
      A_STAT: regRdata = stat;
      A_TIM:  regRdata[DIV_W-1:0] = div;
      default: regRdata = '0;
    endcase
  end

  // R7
  selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstPend != 3'b000 && !wrCtl) |=> (rstPend == 3'b000));
endmodule

// File: rtl/spi_xfer_ctrl.sv
`timescale 1ns/1ps
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  cfg_t  cfg,
  input  logic  start,
  input  logic  ctlRst,
  input  logic  txEmpty,
  input  logic  rxFull,
  output strb_t strb,
  output logic  busy,
  output logic  sclkO,
  output logic  csNO
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOAD, S_LOW, S_HIGH, S_TRAIL} state_t;

  state_t           state;
  logic [DIV_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitLeft;
  logic [CNT_W-1:0] bytesLeft;
  logic             phaseWr, wrThenRd, sclk;
  logic             halfDone, modeOk, stall;

  assign halfDone = (halfCnt == cfg.div);
  assign modeOk   = (cfg.mode == MODE_WO) || (cfg.mode == MODE_RO) || (cfg.mode == MODE_WR);
  assign stall    = phaseWr ? txEmpty : rxFull;
  assign busy     = (state != S_IDLE);
  assign csNO     = (state == S_IDLE);
  assign sclkO    = sclk;

  always_comb begin
    strb = '0;
    case (state)
      S_LOAD: if (!stall) begin
        strb.ldByte = 1'b1;
        strb.ldTx   = phaseWr;
      end
      S_LOW:  strb.sample = halfDone;
      S_HIGH: if (halfDone) begin
        if (bitLeft != '0) strb.shift = 1'b1;
        else               strb.rxPush = !phaseWr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctlRst) begin
      state     <= S_IDLE;
      halfCnt   <= '0;
      bitLeft   <= '0;
      bytesLeft <= '0;
      phaseWr   <= 1'b0;
      wrThenRd  <= 1'b0;
      sclk      <= 1'b0;
    end else begin
      if (state == S_IDLE || state == S_LOAD || halfDone) halfCnt <= '0;
      else                                                 halfCnt <= halfCnt + 1'b1;
      case (state)
        S_IDLE: if (start && modeOk) begin
          phaseWr   <= (cfg.mode != MODE_RO);
          wrThenRd  <= (cfg.mode == MODE_WR);
          bytesLeft <= (cfg.mode == MODE_RO) ? cfg.rcnt : cfg.wcnt;
          state     <= S_LEAD;
        end
        S_LEAD: if (halfDone) state <= S_LOAD;
        S_LOAD: if (!stall) begin
          bitLeft <= cfg.bitsM1;
          state   <= S_LOW;
        end
        S_LOW: if (halfDone) begin
          sclk  <= 1'b1;
          state <= S_HIGH;
        end
        S_HIGH: if (halfDone) begin
          sclk <= 1'b0;
          if (bitLeft != '0) begin
            bitLeft <= bitLeft - 1'b1;
            state   <= S_LOW;
          end else if (bytesLeft != '0) begin
            bytesLeft <= bytesLeft - 1'b1;
            state     <= S_LOAD;
          end else if (phaseWr && wrThenRd) begin
            phaseWr   <= 1'b0;
            bytesLeft <= cfg.rcnt;
            state     <= S_LOAD;
          end else begin
            state <= S_TRAIL;
          end
        end
        S_TRAIL: if (halfDone) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  sclk_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkO |-> !csNO);

  // R12
  sclk_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkO) |-> ($past(halfDone) || $past(ctlRst)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOAD && stall && !ctlRst) |=> (!sclkO && !csNO && $stable(bytesLeft)));
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] DIV_RST    = 8'd3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        sclkO,
  output logic        csNO,
  output logic        mosiO,
  input  logic        misoI
);
  cfg_t  cfg;
  strb_t strb;
  logic  start, ctlRst, txEmpty, rxFull, busy;

  spi_xfer_dp #(.FIFO_DEPTH(FIFO_DEPTH), .DIV_RST(DIV_RST)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .misoI(misoI), .mosiO(mosiO),
    .strb(strb), .busy(busy), .cfg(cfg), .start(start), .ctlRst(ctlRst),
    .txEmpty(txEmpty), .rxFull(rxFull));

  spi_xfer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .start(start), .ctlRst(ctlRst),
    .txEmpty(txEmpty), .rxFull(rxFull), .strb(strb), .busy(busy),
    .sclkO(sclkO), .csNO(csNO));
endmodule

// File: tb/sim_spi_xfer_engine.sv
`timescale 1ns/1ps
module sim_spi_xfer_engine;
  localparam logic [6:0] FMT = 7'h10, TCTL = 7'h20, CMD = 7'h24, DATA = 7'h2C,
                         CTL = 7'h30, STAT = 7'h34, TIM = 7'h40;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regRd = 1'b0, miso = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic sclk, csN, mosi;

  int nChk = 0, nErr = 0, frameBits = 8;
  int sIdx = 0, sBit = 7, bitCnt = 0, pulses = 0, csRises = 0;
  logic firstRise = 1'b0;
  logic [7:0] acc = '0;
  time tFall = 0, lastRise = 0, period = 0, lead = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  spi_xfer_engine #(.FIFO_DEPTH(4), .DIV_RST(8'd1)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclkO(sclk), .csNO(csN),
    .mosiO(mosi), .misoI(miso));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(STAT, s);
      if (!s[0]) break;
    end
  endtask

  // driver side: push a byte into the TX FIFO and the expected MOSI queue
  task automatic sendByte(input logic [7:0] b);
    wr(DATA, {24'b0, b});
    expQ.push_back(b & 8'((1 << frameBits) - 1));
  endtask

  // device model: MISO carries 0xA0+index within each chip-select window
  function automatic logic patBit(input int idx, input int b);
    logic [7:0] p;
    p = 8'hA0 + 8'(idx);
    return p[b];
  endfunction

  always @(negedge csN) begin
    sIdx = 0; sBit = frameBits - 1; miso = patBit(sIdx, sBit);
    tFall = $time; firstRise = 1'b1; pulses = 0; bitCnt = 0; acc = '0;
  end

  always @(negedge sclk) if (!csN) begin
    if (sBit == 0) begin sIdx++; sBit = frameBits - 1; end
    else sBit--;
    miso = patBit(sIdx, sBit);
  end

  always @(posedge csN) csRises++;

  // monitor: assemble MOSI bytes on rising SCLK and compare with the queue
  always @(posedge sclk) begin
    logic [7:0] e;
    pulses++;
    if (bitCnt != 0) period = $time - lastRise;
    lastRise = $time;
    if (firstRise) begin lead = $time - tFall; firstRise = 1'b0; end
    acc = {acc[6:0], mosi};
    bitCnt++;
    if (bitCnt == frameBits) begin
      if (expQ.size() == 0) chk("R2 unexpected MOSI byte", {24'b0, acc}, 32'hFFFF_FFFF);
      else begin
        e = expQ.pop_front();
        chk("R2 MOSI byte", {24'b0, acc}, {24'b0, e});
      end
      bitCnt = 0; acc = '0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    rd(STAT, d); chk("R1 status", d, 32'h0040_0000);
    chk("R1 csN", {31'b0, csN}, 1);
    chk("R1 sclk", {31'b0, sclk}, 0);
    rd(FMT, d);  chk("R1 format", d, 32'h0000_0700);
    rd(TIM, d);  chk("R1 timing", d, 32'd1);
    rd(DATA, d); chk("R9 empty rx read", d, 0);

    // R2 / R5: write-only, three bytes
    sendByte(8'h5A); sendByte(8'hC3); sendByte(8'h81);
    wr(TCTL, (32'd1 << 24) | (32'd2 << 12));
    c0 = csRises;
    wr(CMD, 32'd0);
    rd(STAT, d); chk("R5 busy after command", {31'b0, d[0]}, 1);
    waitIdle();
    chk("R2 all bytes sent", expQ.size(), 0);
    rd(STAT, d); chk("R2 rx untouched", {27'b0, d[12:8]}, 0);
    chk("R5 one cs window", csRises - c0, 1);

    // R3: read-only, three bytes
    for (int i = 0; i < 3; i++) expQ.push_back(8'h00);
    wr(TCTL, (32'd2 << 24) | 32'd2);
    wr(CMD, 32'd1);
    waitIdle();
    rd(STAT, d); chk("R3 rx level", {27'b0, d[12:8]}, 3);
    for (int i = 0; i < 3; i++) begin
      rd(DATA, d); chk("R3 rx byte", d, 32'hA0 + i);
    end
    chk("R3 mosi low", expQ.size(), 0);

    // R4: write two then read two
    sendByte(8'h9F); sendByte(8'h00);
    expQ.push_back(8'h00); expQ.push_back(8'h00);
    wr(TCTL, (32'd3 << 24) | (32'd1 << 12) | 32'd1);
    c0 = csRises;
    wr(CMD, 32'd0);
    waitIdle();
    chk("R4 pulses", pulses, 32);
    chk("R4 single cs window", csRises - c0, 1);
    rd(STAT, d); chk("R4 rx level", {27'b0, d[12:8]}, 2);
    rd(DATA, d); chk("R4 rx byte0", d, 32'hA2);
    rd(DATA, d); chk("R4 rx byte1", d, 32'hA3);

    // R12 / R11: divider 2
    wr(TIM, 32'd2);
    rd(TIM, d); chk("R12 timing readback", d, 2);
    sendByte(8'h3C);
    wr(TCTL, 32'd1 << 24);
    wr(CMD, 32'd0);
    waitIdle();
    chk("R12 sclk period ns", 32'(period), 30);
    chk("R11 cs lead at least half period", {31'b0, (lead >= 15)}, 1);
    wr(TIM, 32'd1);

    // R13: 4-bit frame, then an oversize field
    wr(FMT, 32'h0000_0300); frameBits = 4;
    sendByte(8'h0B);
    wr(CMD, 32'd0);
    waitIdle();
    chk("R13 four pulses", pulses, 4);
    wr(FMT, 32'h0000_1400); frameBits = 8;
    sendByte(8'hA5);
    wr(CMD, 32'd0);
    waitIdle();
    chk("R13 clamp to eight", pulses, 8);
    wr(FMT, 32'h0000_0700);

    // R8: fill, overflow push dropped
    for (int i = 1; i <= 4; i++) sendByte(8'(i * 8'h11));
    wr(DATA, 32'h55);
    rd(STAT, d); chk("R8 tx full flag", {31'b0, d[23]}, 1);
    wr(TCTL, (32'd1 << 24) | (32'd3 << 12));
    wr(CMD, 32'd0);
    waitIdle();
    chk("R8 four bytes sent", expQ.size(), 0);
    rd(STAT, d); chk("R8 extra push dropped", {31'b0, d[22]}, 1);

    // R10: TX underrun stall
    wr(TCTL, (32'd1 << 24) | (32'd5 << 12));
    for (int i = 0; i < 4; i++) sendByte(8'h61 + 8'(i));
    wr(CMD, 32'd0);
    repeat (150) @(negedge clk);
    rd(STAT, d); chk("R10 busy while tx stalled", {31'b0, d[0]}, 1);
    chk("R10 cs low while stalled", {31'b0, csN}, 0);
    chk("R10 bytes pending", expQ.size(), 0);
    sendByte(8'h65); sendByte(8'h66);
    waitIdle();
    chk("R10 tx resumed", expQ.size(), 0);

    // R10: RX full stall
    for (int i = 0; i < 6; i++) expQ.push_back(8'h00);
    wr(TCTL, (32'd2 << 24) | 32'd5);
    wr(CMD, 32'd0);
    repeat (300) @(negedge clk);
    rd(STAT, d);
    chk("R10 busy while rx full", {31'b0, d[0]}, 1);
    chk("R10 rx level at depth", {27'b0, d[12:8]}, 4);
    for (int i = 0; i < 4; i++) begin rd(DATA, d); chk("R10 rx byte", d, 32'hA0 + i); end
    waitIdle();
    for (int i = 4; i < 6; i++) begin rd(DATA, d); chk("R10 rx byte", d, 32'hA0 + i); end
    rd(STAT, d); chk("R10 rx drained", {27'b0, d[12:8]}, 0);

    // R6: unsupported phase code
    wr(TCTL, 32'd7 << 24);
    wr(DATA, 32'h77);
    wr(CMD, 32'd0);
    repeat (20) @(negedge clk);
    rd(STAT, d);
    chk("R6 not busy", {31'b0, d[0]}, 0);
    chk("R6 tx kept", {31'b0, d[22]}, 0);

    // R7: FIFO resets and controller abort
    wr(CTL, 32'h6);
    rd(CTL, d); chk("R7 bits self clear", d, 0);
    rd(STAT, d); chk("R7 fifos flushed", d, 32'h0040_0000);
    wr(TCTL, 32'd1 << 24);
    wr(CMD, 32'd0);
    repeat (20) @(negedge clk);
    chk("R7 stalled before abort", {31'b0, csN}, 0);
    wr(CTL, 32'h1);
    rd(STAT, d); chk("R7 abort clears busy", {31'b0, d[0]}, 0);
    chk("R7 abort raises cs", {31'b0, csN}, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule